// File: doc/BRIEF.md
# Blanking Palette Lookup Memory

This block is the colour lookup table of a display controller. It holds one true-colour value for each palettized pixel index. A processor loads the table through a bus-slave port. That port uses Wishbone-style handshaking and accepts writes only. Any read attempted on it is answered with an error.

The second port is a purely combinational lookup path. A pixel index goes in and the stored colour comes out with no clock delay. While the blanking input is high, the colour output is forced to zero.

The bus port also merges chained acknowledge, error and return-data inputs into its own responses. Several slaves can therefore share one return path back to the master. The bus data width, bus address width, index width and colour width are all parameters.

Top module: `palette_lut`

## Requirements
- R1: When `bus_cyc_i`, `bus_stb_i` and `bus_we_i` are all high and the block is out of reset, `bus_ack_o` is high in that same cycle and the block adds no error.
- R2: When `bus_cyc_i` and `bus_stb_i` are high and `bus_we_i` is low, `bus_err_o` is high in that same cycle. No local acknowledge is given, and the table is left unchanged.
- R3: If `bus_cyc_i` or `bus_stb_i` is low, the block adds no acknowledge or error, and no table entry is written, whatever `bus_we_i`, address and data are.
- R4: An accepted write stores `bus_dat_i[COLOR_W-1:0]` at the rising clock edge. The store goes to index `bus_adr_i[IDX_W-1:0]`; higher address bits are ignored, so addresses alias modulo 2^IDX_W.
- R5: While `blank_i` is high, every bit of `pix_rgb_o` is 0, regardless of the table contents.
- R6: While `blank_i` is low, `pix_rgb_o` equals the entry at `pix_idx_i` and follows a change of `pix_idx_i` with no clock edge.
- R7: `bus_ack_o` is `chain_ack_i` OR the local acknowledge, and `bus_err_o` is `chain_err_i` OR the local error. `bus_dat_o` always equals `chain_dat_i`, because the local read data is zero.
- R8: While `rst_ni` is low, and until the second rising clock edge after it rises, the block adds no acknowledge or error and ignores writes. Table contents are kept across reset.
- R9: When the bus writes the entry that the lookup port is currently selecting, `pix_rgb_o` shows the new value right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cyc_i | input | 1 | Bus cycle frame |
| bus_stb_i | input | 1 | Strobe selecting this slave |
| bus_we_i | input | 1 | High for master-to-slave transfer |
| bus_adr_i | input | BUS_AW | Bus address |
| bus_dat_i | input | BUS_DW | Bus write data |
| bus_dat_o | output | BUS_DW | Return data (chain data merged with local zero) |
| bus_ack_o | output | 1 | Merged acknowledge |
| bus_err_o | output | 1 | Merged error |
| chain_ack_i | input | 1 | Acknowledge from upstream slave in the chain |
| chain_err_i | input | 1 | Error from upstream slave in the chain |
| chain_dat_i | input | BUS_DW | Return data from upstream slave in the chain |
| blank_i | input | 1 | Blanking, forces colour output to zero |
| pix_idx_i | input | IDX_W | Palettized pixel index |
| pix_rgb_o | output | COLOR_W | True-colour output |

## Verification
The bound checker checks the bus response on every clock: writes acknowledged, reads errored, idle cycles silent, chain data passed through, and quiet responses during the reset window. It also checks the blanking force to zero each cycle. Only the bench's scenarios can show what the table actually holds. These scenarios cover address aliasing, untouched entries after rejected reads and idle strobes, kept contents across reset, the combinational follow of the index without a clock, and a read and write to the same entry in the same cycle.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } pal_op_e;

  // Decode of one bus beat; 'ready' gates everything during the reset window.
  function automatic pal_op_e classify(input logic cyc, input logic stb,
                                       input logic we, input logic ready);
    pal_op_e op;
    op = OP_NONE;
    if (ready && cyc && stb) begin
      op = we ? OP_WRITE : OP_READ;
    end
    return op;
  endfunction

endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign ready_o = sync_q[STAGES-1];

endmodule

// File: rtl/pal_bus_slave.sv
module pal_bus_slave
  import pal_pkg::*;
#(
  parameter int BUS_DW = 32
) (
  input  logic              ready_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic              chain_ack_i,
  input  logic              chain_err_i,
  input  logic [BUS_DW-1:0] chain_dat_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [BUS_DW-1:0] dat_o,
  output logic              wr_en_o
);

  pal_op_e           op;
  logic              loc_ack;
  logic              loc_err;
  logic [BUS_DW-1:0] loc_dat;

  always_comb begin
    op      = classify(cyc_i, stb_i, we_i, ready_i);
    loc_ack = (op == OP_WRITE);
    loc_err = (op == OP_READ);
    loc_dat = '0;
  end

  assign wr_en_o = loc_ack;
  assign ack_o   = chain_ack_i | loc_ack;
  assign err_o   = chain_err_i | loc_err;
  assign dat_o   = chain_dat_i | loc_dat;

endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 24,
  parameter int BUS_AW  = 10,
  parameter int BUS_DW  = 32
) (
  input  logic               clk_i,
  input  logic               wr_en_i,
  input  logic [BUS_AW-1:0]  wr_adr_i,
  input  logic [BUS_DW-1:0]  wr_dat_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [COLOR_W-1:0] rd_dat_o
);

  localparam int DEPTH = 1 << IDX_W;

  logic [COLOR_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]   wr_idx;
  logic [COLOR_W-1:0] wr_val;

  generate
    if (BUS_AW > IDX_W) begin : g_adr_trunc
      logic unused_adr_hi;
      assign wr_idx        = wr_adr_i[IDX_W-1:0];
      assign unused_adr_hi = ^wr_adr_i[BUS_AW-1:IDX_W];
    end else begin : g_adr_ext
      assign wr_idx = IDX_W'(wr_adr_i);
    end

    if (BUS_DW > COLOR_W) begin : g_dat_trunc
      logic unused_dat_hi;
      assign wr_val        = wr_dat_i[COLOR_W-1:0];
      assign unused_dat_hi = ^wr_dat_i[BUS_DW-1:COLOR_W];
    end else begin : g_dat_ext
      assign wr_val = COLOR_W'(wr_dat_i);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_q[wr_idx] <= wr_val;
    end
  end

  assign rd_dat_o = mem_q[rd_idx_i];

endmodule

// File: rtl/pal_blank.sv
module pal_blank #(
  parameter int COLOR_W = 24
) (
  input  logic               blank_i,
  input  logic [COLOR_W-1:0] dat_i,
  output logic [COLOR_W-1:0] dat_o
);

  generate
    for (genvar b = 0; b < COLOR_W; b++) begin : g_bit
      assign dat_o[b] = dat_i[b] & ~blank_i;
    end
  endgenerate

endmodule

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int COLOR_W = 24,
  parameter int IDX_W   = 8,
  parameter int BUS_DW  = 32,
  parameter int BUS_AW  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_cyc_i,
  input  logic               bus_stb_i,
  input  logic               bus_we_i,
  input  logic [BUS_AW-1:0]  bus_adr_i,
  input  logic [BUS_DW-1:0]  bus_dat_i,
  output logic [BUS_DW-1:0]  bus_dat_o,
  output logic               bus_ack_o,
  output logic               bus_err_o,
  input  logic               chain_ack_i,
  input  logic               chain_err_i,
  input  logic [BUS_DW-1:0]  chain_dat_i,
  input  logic               blank_i,
  input  logic [IDX_W-1:0]   pix_idx_i,
  output logic [COLOR_W-1:0] pix_rgb_o
);

  localparam int SYNC_STAGES = 2;

  logic               ready;
  logic               wr_en;
  logic [COLOR_W-1:0] raw_rgb;

  pal_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_o (ready)
  );

  pal_bus_slave #(.BUS_DW(BUS_DW)) u_bus (
    .ready_i     (ready),
    .cyc_i       (bus_cyc_i),
    .stb_i       (bus_stb_i),
    .we_i        (bus_we_i),
    .chain_ack_i (chain_ack_i),
    .chain_err_i (chain_err_i),
    .chain_dat_i (chain_dat_i),
    .ack_o       (bus_ack_o),
    .err_o       (bus_err_o),
    .dat_o       (bus_dat_o),
    .wr_en_o     (wr_en)
  );

  pal_store #(
    .IDX_W   (IDX_W),
    .COLOR_W (COLOR_W),
    .BUS_AW  (BUS_AW),
    .BUS_DW  (BUS_DW)
  ) u_store (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en),
    .wr_adr_i (bus_adr_i),
    .wr_dat_i (bus_dat_i),
    .rd_idx_i (pix_idx_i),
    .rd_dat_o (raw_rgb)
  );

  pal_blank #(.COLOR_W(COLOR_W)) u_blank (
    .blank_i (blank_i),
    .dat_i   (raw_rgb),
    .dat_o   (pix_rgb_o)
  );

endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk #(
  parameter int COLOR_W = 24,
  parameter int IDX_W   = 8,
  parameter int BUS_DW  = 32,
  parameter int BUS_AW  = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_cyc_i,
  input logic               bus_stb_i,
  input logic               bus_we_i,
  input logic [BUS_DW-1:0]  bus_dat_o,
  input logic               bus_ack_o,
  input logic               bus_err_o,
  input logic               chain_ack_i,
  input logic               chain_err_i,
  input logic [BUS_DW-1:0]  chain_dat_i,
  input logic               blank_i,
  input logic [COLOR_W-1:0] pix_rgb_o
);

  // Own count of edges since reset release; live once two have passed.
  logic [1:0] edges_q;
  logic       live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edges_q <= 2'd0;
    end else if (edges_q != 2'd2) begin
      edges_q <= edges_q + 2'd1;
    end
  end

  assign live = (edges_q == 2'd2);

  a_r1_write_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && bus_cyc_i && bus_stb_i && bus_we_i) |-> (bus_ack_o && (bus_err_o == chain_err_i)));

  a_r2_read_errors: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && bus_cyc_i && bus_stb_i && !bus_we_i) |-> (bus_err_o && (bus_ack_o == chain_ack_i)));

  a_r3_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_cyc_i && bus_stb_i) |-> ((bus_ack_o == chain_ack_i) && (bus_err_o == chain_err_i)));

  a_r5_blank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> (pix_rgb_o == '0));

  a_r7_data_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dat_o == chain_dat_i);

  a_r8_reset_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |-> ((bus_ack_o == chain_ack_i) && (bus_err_o == chain_err_i)));

endmodule

bind palette_lut palette_lut_chk #(
  .COLOR_W (COLOR_W),
  .IDX_W   (IDX_W),
  .BUS_DW  (BUS_DW),
  .BUS_AW  (BUS_AW)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_cyc_i   (bus_cyc_i),
  .bus_stb_i   (bus_stb_i),
  .bus_we_i    (bus_we_i),
  .bus_dat_o   (bus_dat_o),
  .bus_ack_o   (bus_ack_o),
  .bus_err_o   (bus_err_o),
  .chain_ack_i (chain_ack_i),
  .chain_err_i (chain_err_i),
  .chain_dat_i (chain_dat_i),
  .blank_i     (blank_i),
  .pix_rgb_o   (pix_rgb_o)
);

// File: tb/palette_lut_tb_top.sv
`timescale 1ns/1ps
module palette_lut_tb_top;

  localparam int COLOR_W = 24;
  localparam int IDX_W   = 8;
  localparam int BUS_DW  = 32;
  localparam int BUS_AW  = 10;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic               bus_cyc_i, bus_stb_i, bus_we_i;
  logic [BUS_AW-1:0]  bus_adr_i;
  logic [BUS_DW-1:0]  bus_dat_i, bus_dat_o, chain_dat_i;
  logic               bus_ack_o, bus_err_o, chain_ack_i, chain_err_i;
  logic               blank_i;
  logic [IDX_W-1:0]   pix_idx_i;
  logic [COLOR_W-1:0] pix_rgb_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk_i = ~clk_i;

  palette_lut #(.COLOR_W(COLOR_W), .IDX_W(IDX_W), .BUS_DW(BUS_DW), .BUS_AW(BUS_AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_cyc_i(bus_cyc_i), .bus_stb_i(bus_stb_i),
    .bus_we_i(bus_we_i), .bus_adr_i(bus_adr_i), .bus_dat_i(bus_dat_i), .bus_dat_o(bus_dat_o),
    .bus_ack_o(bus_ack_o), .bus_err_o(bus_err_o), .chain_ack_i(chain_ack_i),
    .chain_err_i(chain_err_i), .chain_dat_i(chain_dat_i), .blank_i(blank_i),
    .pix_idx_i(pix_idx_i), .pix_rgb_o(pix_rgb_o)
  );

  // Vector: {kind[1:0], adr[9:0], dat[31:0], exp_ack, exp_err}
  // kind 0 = cyc+stb+we, 1 = cyc+stb read, 2 = cyc only (we high), 3 = stb only (we high)
  localparam int NVEC = 8;
  localparam logic [45:0] VEC [NVEC] = '{
    {2'd0, 10'h003, 32'hAA112233, 1'b1, 1'b0},
    {2'd0, 10'h07F, 32'h00445566, 1'b1, 1'b0},
    {2'd1, 10'h003, 32'h00DDDDDD, 1'b0, 1'b1},
    {2'd2, 10'h003, 32'h00999999, 1'b0, 1'b0},
    {2'd0, 10'h1FF, 32'h12345678, 1'b1, 1'b0},
    {2'd3, 10'h07F, 32'h00888888, 1'b0, 1'b0},
    {2'd0, 10'h100, 32'h00ABCDEF, 1'b1, 1'b0},
    {2'd0, 10'h010, 32'hFF010203, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    bus_cyc_i = 1'b0; bus_stb_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic look(input string req, input logic [7:0] idx, input logic [23:0] exp);
    pix_idx_i = idx;
    #0.5;
    check(req, 32'(pix_rgb_o), 32'(exp));
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; bus_idle(); bus_adr_i = '0; bus_dat_i = '0;
    chain_ack_i = 1'b0; chain_err_i = 1'b0; chain_dat_i = '0;
    blank_i = 1'b0; pix_idx_i = '0;
    // R8: reset state, and a write attempt while in reset is not acknowledged
    @(negedge clk_i);
    bus_cyc_i = 1'b1; bus_stb_i = 1'b1; bus_we_i = 1'b1; #0.5;
    check("R8 reset ack", 32'(bus_ack_o), 32'd0);
    check("R8 reset err", 32'(bus_err_o), 32'd0);
    bus_idle();
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] kind;
      kind      = VEC[i][45:44];
      bus_adr_i = VEC[i][43:34];
      bus_dat_i = VEC[i][33:2];
      bus_cyc_i = (kind != 2'd3);
      bus_stb_i = (kind != 2'd2);
      bus_we_i  = (kind != 2'd1);
      #0.5;
      check($sformatf("R1/R2/R3 vec%0d ack", i), 32'(bus_ack_o), 32'(VEC[i][1]));
      check($sformatf("R1/R2/R3 vec%0d err", i), 32'(bus_err_o), 32'(VEC[i][0]));
      @(negedge clk_i);
      bus_idle();
    end

    // R4 contents and aliasing; R2/R3 left entries untouched
    look("R4 idx03 (R2 R3 untouched)", 8'h03, 24'h112233);
    look("R4 idx7F (R3 untouched)", 8'h7F, 24'h445566);
    look("R4 idxFF alias", 8'hFF, 24'h345678);
    look("R4 idx00 alias", 8'h00, 24'hABCDEF);
    // R6 combinational follow: no clock edge between these lookups
    look("R6 idx10 no clock", 8'h10, 24'h010203);
    look("R6 idx03 no clock", 8'h03, 24'h112233);
    // R5 blanking
    blank_i = 1'b1;
    look("R5 blank idx03", 8'h03, 24'h000000);
    look("R5 blank idxFF", 8'hFF, 24'h000000);
    blank_i = 1'b0;

    // R7 chain merging
    @(negedge clk_i);
    chain_ack_i = 1'b1; chain_dat_i = 32'hC0FFEE01; #0.5;
    check("R7 chain ack", 32'(bus_ack_o), 32'd1);
    check("R7 chain dat", bus_dat_o, 32'hC0FFEE01);
    chain_ack_i = 1'b0; chain_err_i = 1'b1; #0.5;
    check("R7 chain err", 32'(bus_err_o), 32'd1);
    check("R7 no ack", 32'(bus_ack_o), 32'd0);
    chain_err_i = 1'b0; chain_dat_i = '0;

    // R9 read during write at the same entry
    @(negedge clk_i);
    pix_idx_i = 8'h20;
    bus_adr_i = 10'h020; bus_dat_i = 32'h00777777;
    bus_cyc_i = 1'b1; bus_stb_i = 1'b1; bus_we_i = 1'b1;
    @(posedge clk_i); #0.5;
    check("R9 new value after edge", 32'(pix_rgb_o), 32'h00777777);
    @(negedge clk_i); bus_idle();

    // R8: reset window ignores writes, contents kept
    rst_ni = 1'b0;
    bus_adr_i = 10'h003; bus_dat_i = 32'h00DEAD00;
    bus_cyc_i = 1'b1; bus_stb_i = 1'b1; bus_we_i = 1'b1; #0.5;
    check("R8 in reset ack", 32'(bus_ack_o), 32'd0);
    @(negedge clk_i); rst_ni = 1'b1; #0.5;
    check("R8 after release ack", 32'(bus_ack_o), 32'd0);
    @(negedge clk_i); #0.5;
    check("R8 one edge ack", 32'(bus_ack_o), 32'd0);
    @(negedge clk_i); #0.5;
    check("R8 two edges ack", 32'(bus_ack_o), 32'd1);
    bus_idle();
    look("R8 contents kept", 8'h03, 24'h112233);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule